// File: doc/BRIEF.md
# I2C byte shift register

This block is the data path of a two-wire serial peripheral. It holds one 8-bit byte. The same register carries the byte being sent and the byte being received. Software reaches it through a simple register port. A write loads a byte, and a read returns the current contents at any time.

The serial side takes the raw clock and data line levels. It passes them through a two-stage synchronizer and then detects edges. In receive mode, every rising clock edge shifts the register left and places the line level in the least significant bit. In transmit mode, the most significant bit is driven onto the data output. The register shifts left shortly after each falling clock edge, so the output never changes while the clock is high. A 3-bit counter tracks bit positions within the byte and reports when a byte completes. A write made in master mode also requests that the clock generator start.

Top module: `i2c_shift_unit`

## Requirements
- R1: After reset the register reads 0 and the bit counter reads 0. `rd_data` always shows the register contents, whatever the value of `if_enable`.
- R2: When `wr_en` and `if_enable` are both 1 at a clock edge, the write is accepted and `rd_data` equals `wr_data` after that edge.
- R3: A write made with `if_enable` = 0 is ignored. The register, the counter and `scl_start` are left unchanged.
- R4: An accepted write clears the bit counter to 0, including in the middle of a byte.
- R5: `scl_start` is 1 for exactly one cycle, directly after an accepted write with `master_mode` = 1. Otherwise it stays 0.
- R6: With `xmit` = 0, each rising edge on `scl_in` shifts the register left by one and places the level of `sda_in` in bit 0. The new value appears on the third clock edge after `scl_in` rises, and not before.
- R7: `sda_out` equals register bit 7 when `xmit` = 1, and is 1 (line released) when `xmit` = 0. In transmit mode, each falling edge shifts the register left. The vacated bit 0 is filled with the `sda_in` level sampled at the preceding rising edge.
- R8: In transmit mode the next bit appears on `sda_out` at the third clock edge after `scl_in` falls. Outside a write, `sda_out` changes only while the synchronized clock is low.
- R9: While `if_enable` = 1, the bit counter advances by one on each synchronized rising edge. When it wraps from 7 to 0, `byte_done` is 1 for exactly one cycle.
- R10: While `if_enable` = 0, serial edges neither shift the register nor advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte to load |
| rd_data | output | 8 | Register contents |
| if_enable | input | 1 | Interface enable; gates writes and shifting |
| master_mode | input | 1 | Master mode; an accepted write requests the clock |
| xmit | input | 1 | 1 = transmit, 0 = receive |
| scl_in | input | 1 | Raw serial clock level |
| sda_in | input | 1 | Raw serial data level |
| sda_out | output | 1 | Serial data drive value; 1 means released |
| bit_cnt | output | 3 | Bit position within the byte |
| byte_done | output | 1 | One-cycle pulse when the counter wraps |
| scl_start | output | 1 | One-cycle request to start clock generation |

## Verification
Register-port results are due one edge after the request. An accepted write shows on `rd_data`, clears `bit_cnt`, and raises `scl_start` at the first edge. Serial results are due three edges after a line change: two synchronizer stages, then the shift itself. The bench drives `scl_in` at a falling clock edge and samples at falling edges. It checks that the register and `sda_out` still hold their old values after the second rising edge and show the new value after the third. All 256 byte values are swept in both receive and transmit. The counter, `byte_done` and the readback value are compared with values computed from the byte itself.

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      if_enable,
  input  logic                      master_mode,
  input  logic                      xmit,
  input  logic                      scl_in,
  input  logic                      sda_in,
  output logic                      sda_out,
  output logic [$clog2(DATA_W)-1:0] bit_cnt,
  output logic                      byte_done,
  output logic                      scl_start
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [1:0]        scl_sync, sda_sync;
  logic              scl_q, bus_bit;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire scl_now = scl_sync[1];
  wire sda_now = sda_sync[1];
  wire rise    = scl_now & ~scl_q;
  wire fall    = ~scl_now & scl_q;
  wire wr_ok   = wr_en & if_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      bus_bit  <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_now;
      if (rise) bus_bit <= sda_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (wr_ok)
      shreg <= wr_data;
    else if (if_enable && !xmit && rise)
      shreg <= {shreg[DATA_W-2:0], sda_now};
    else if (if_enable && xmit && fall)
      shreg <= {shreg[DATA_W-2:0], bus_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      byte_done <= 1'b0;
      scl_start <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      scl_start <= wr_ok & master_mode;
      if (wr_ok)
        cnt <= '0;
      else if (if_enable && rise) begin
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_done <= 1'b1;
        end else
          cnt <= cnt + 1'b1;
      end
    end
  end

  assign rd_data = shreg;
  assign bit_cnt = cnt;
  assign sda_out = xmit ? shreg[DATA_W-1] : 1'b1;
endmodule

// File: rtl/i2c_shift_unit_chk.sv
module i2c_shift_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      if_enable,
  input logic                      master_mode,
  input logic                      xmit,
  input logic [DATA_W-1:0]         rd_data,
  input logic [$clog2(DATA_W)-1:0] bit_cnt,
  input logic                      byte_done,
  input logic                      scl_start,
  input logic                      sda_out,
  input logic                      scl_now
);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_enable |=> $stable(rd_data) && $stable(bit_cnt));
  // R4
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && if_enable) |=> bit_cnt == '0);
  // R5
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_start |-> $past(wr_en && if_enable && master_mode));
  // R9
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> bit_cnt == '0 && $past(bit_cnt) == '1);
  // R8
  sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit && $past(xmit) && !$past(wr_en && if_enable) && sda_out != $past(sda_out))
      |-> !$past(scl_now));
endmodule

bind i2c_shift_unit i2c_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .if_enable(if_enable),
  .master_mode(master_mode), .xmit(xmit), .rd_data(rd_data),
  .bit_cnt(bit_cnt), .byte_done(byte_done), .scl_start(scl_start),
  .sda_out(sda_out), .scl_now(scl_now)
);

// File: tb/i2c_shift_unit_tb.sv
module i2c_shift_unit_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, if_enable = 0, master_mode = 0, xmit = 0;
  logic scl_in = 1, sda_in = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [2:0] bit_cnt;
  logic sda_out, byte_done, scl_start;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_shift_unit u_dut (.*);

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_data = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic rx_byte(logic [7:0] b);
    logic [7:0] prev;
    for (int i = 0; i < 8; i++) begin
      prev = rd_data;
      sda_in = b[7-i];
      tick();
      scl_in = 1;
      tick(2);
      chk("R6 early", rd_data, prev);
      tick();
      chk("R6 shift", rd_data, {prev[6:0], b[7-i]});
      chk("R9 count", bit_cnt, (i + 1) % 8);
      chk("R9 done", byte_done, i == 7);
      tick();
      chk("R9 pulse", byte_done, 0);
      scl_in = 0;
      tick(4);
    end
    chk("R6 byte", rd_data, b);
  endtask

  task automatic tx_byte(logic [7:0] b);
    wr(b);
    chk("R2 load", rd_data, b);
    chk("R7 msb", sda_out, b[7]);
    for (int i = 0; i < 8; i++) begin
      sda_in = sda_out;
      tick();
      scl_in = 1;
      for (int k = 0; k < 4; k++) begin
        tick();
        chk("R8 high", sda_out, b[7-i]);
      end
      scl_in = 0;
      tick(2);
      chk("R8 early", sda_out, b[7-i]);
      tick();
      chk("R8 next", sda_out, (i < 7) ? b[6-i] : b[7]);
      tick();
    end
    chk("R7 readback", rd_data, b);
    chk("R9 wrap", bit_cnt, 0);
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    chk("R1 reset", rd_data, 0);
    chk("R1 cnt", bit_cnt, 0);
    chk("R7 release", sda_out, 1);
    scl_in = 0;
    tick(4);
    wr(8'h5A);
    chk("R3 ignored", rd_data, 0);
    chk("R3 nostart", scl_start, 0);
    if_enable = 1;
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 2; m++) begin
        if_enable = e[0]; master_mode = m[0];
        wr(8'h30 + 8'(e * 2 + m));
        chk("R5 start", scl_start, e & m);
        tick();
        chk("R5 one", scl_start, 0);
      end
    chk("R2 last", rd_data, 8'h33);
    if_enable = 0;
    chk("R1 read", rd_data, 8'h33);
    for (int i = 0; i < 3; i++) begin
      sda_in = 0; tick(); scl_in = 1; tick(4); scl_in = 0; tick(4);
    end
    chk("R10 reg", rd_data, 8'h33);
    chk("R10 cnt", bit_cnt, 0);
    if_enable = 1; master_mode = 0;
    for (int i = 0; i < 3; i++) begin
      sda_in = 1; tick(); scl_in = 1; tick(4); scl_in = 0; tick(4);
    end
    chk("R9 mid", bit_cnt, 3);
    wr(8'hC3);
    chk("R4 clear", bit_cnt, 0);
    chk("R2 mid", rd_data, 8'hC3);
    for (int v = 0; v < 256; v++) rx_byte(8'(v));
    xmit = 1;
    for (int v = 0; v < 256; v++) tx_byte(8'(v ^ 8'hA5));
    xmit = 0;
    tick();
    chk("R7 idle", sda_out, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule